// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block owns the internal core reset of a microcontroller from the moment power is applied. It watches a supply-good flag. When the flag rises, the block makes a one-cycle power-on pulse. It then keeps the core in reset through two waits in a row:

1. A fixed power-up delay, counted on a free-running timer clock that runs whether or not the oscillator has settled.
2. An oscillator start-up delay of 1024 oscillator periods, counted on the oscillator clock itself.

When the second wait ends, the core reset is released and the core begins fetching from address zero.

The five phases are shown on a status output. A second status bit records whether the most recent reset came from power-on or from the external reset pin. An external reset while the core runs sends the block back into the oscillator wait only, because supply and oscillator are already known to be good. Losing the supply in any phase returns the block at once to the powered-off phase and clears both delays.

The sequencer state machine lives in the timer-clock domain. The oscillator count lives in the oscillator domain. The two are linked by a four-phase request and done handshake through two-flop synchronisers.

Top module: `por_sequencer`

## Requirements
- R1: While the synchronised supply-good is low, the phase output reads 0 (powered off) and core reset is high. A falling supply-good reaches this state within 3 timer cycles from any phase. Both delays restart from zero on the next power-up.
- R2: Core reset is high in every phase except the run phase (phase code 4), and low in the run phase.
- R3: A rising supply-good enters the power-on pulse phase (code 1) within 4 timer cycles. That phase lasts exactly one timer cycle and is followed by the power-up wait (code 2).
- R4: The power-up wait (code 2) lasts exactly PWRT_CYC timer cycles and is followed by the oscillator wait (code 3).
- R5: The oscillator wait lasts at least OST_CYC oscillator cycles (default 1024) before the run phase (code 4) is entered. The synchronisation margin stays within 14 oscillator cycles when the timer clock is the faster one.
- R6: Once in the run phase, the block stays there while supply-good stays high and external reset stays low.
- R7: External reset asserted in the run phase enters the oscillator wait (code 3) within 4 timer cycles, without passing through the power-up wait, and sets the reset-source bit to 1.
- R8: While external reset stays asserted in the oscillator wait, the block stays in that phase. The full OST_CYC oscillator count starts only after external reset is released.
- R9: External reset asserted during the power-on pulse or the power-up wait has no effect. The power-up wait keeps its length, and the reset-source bit reads 0 when the run phase is reached.
- R10: After a power-on sequence, the reset-source bit reads 0 (power-on).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmr_clk_i | input | 1 | Free-running timer clock; the sequencer and power-up count run on it |
| osc_clk_i | input | 1 | Oscillator clock; the start-up count runs on it |
| supply_ok_i | input | 1 | Supply-good flag from the analog detector, asynchronous |
| ext_rst_i | input | 1 | External reset request, active high, asynchronous |
| core_rst_o | output | 1 | Core reset, active high, registered in the timer domain |
| phase_o | output | 3 | Active phase: 0 off, 1 pulse, 2 power-up wait, 3 oscillator wait, 4 run |
| rst_src_o | output | 1 | Source of the last reset: 0 power-on, 1 external |

## Verification
The assertions assume that supply-good and external reset are level signals that stay put for several cycles of the slower clock. They also assume that both clocks run whenever supply-good is high, so the handshake always completes. The stimulus holds every external reset for at least four timer cycles, which is well over two oscillator periods. Supply drops are swept across every timer-cycle offset of the power-up and early oscillator phases, with supply held low long enough for both synchronisers to settle. Oscillator-wait lengths are measured in oscillator edges against the lower bound OST_CYC, plus a margin for the handshake latency.

// File: rtl/porseq_pkg.sv
package porseq_pkg;

  // Phase codes are visible on phase_o; their values are part of the interface.
  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_POR  = 3'd1,
    PH_PWRT = 3'd2,
    PH_OST  = 3'd3,
    PH_RUN  = 3'd4
  } phase_e;

endpackage

// File: rtl/porseq_sync.sv
module porseq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stage_q[i] <= stage_q[i-1];
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/porseq_pwrt_cnt.sv
module porseq_pwrt_cnt #(
  parameter int PWRT_CYC = 4096
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int CW = (PWRT_CYC > 2) ? $clog2(PWRT_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(PWRT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (en && cnt_q != LAST_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == LAST_V);

endmodule

// File: rtl/porseq_ost_cnt.sv
module porseq_ost_cnt #(
  parameter int OST_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic req_async,
  output logic done
);

  localparam int CW = (OST_CYC > 2) ? $clog2(OST_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(OST_CYC - 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  porseq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk (osc_clk),
    .d   (req_async),
    .q   (req_s)
  );

  // Request low clears the count: this is both the supply-loss clear and
  // the return-to-zero half of the handshake.
  always_ff @(posedge osc_clk) begin
    if (!req_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST_V) done_q <= 1'b1;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;

  // R5: done only rises after the count reached its last value
  a_r5_done_after_full: assert property (@(posedge osc_clk) disable iff (!req_s)
    $rose(done_q) |-> $past(cnt_q) == LAST_V);

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int PWRT_CYC    = 4096,
  parameter int OST_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       tmr_clk_i,
  input  logic       osc_clk_i,
  input  logic       supply_ok_i,
  input  logic       ext_rst_i,
  output logic       core_rst_o,
  output logic [2:0] phase_o,
  output logic       rst_src_o
);
  import porseq_pkg::*;

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_v, sync_v;
  logic             pg_s, ext_s, done_s;
  logic             done_osc;
  logic             pwrt_last;

  phase_e state_q, state_d;
  logic   req_q, req_d;
  logic   src_q;
  logic   core_rst_q;

  assign raw_v = {supply_ok_i, ext_rst_i, done_osc};

  porseq_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_tmr_sync (
    .clk (tmr_clk_i),
    .d   (raw_v),
    .q   (sync_v)
  );

  assign pg_s   = sync_v[2];
  assign ext_s  = sync_v[1];
  assign done_s = sync_v[0];

  porseq_pwrt_cnt #(.PWRT_CYC(PWRT_CYC)) u_pwrt (
    .clk  (tmr_clk_i),
    .clr  (state_q != PH_PWRT),
    .en   (state_q == PH_PWRT),
    .last (pwrt_last)
  );

  porseq_ost_cnt #(.OST_CYC(OST_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .osc_clk   (osc_clk_i),
    .req_async (req_q),
    .done      (done_osc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_OFF:  state_d = PH_POR;
      PH_POR:  state_d = PH_PWRT;
      PH_PWRT: if (pwrt_last) state_d = PH_OST;
      PH_OST:  if (req_q && done_s && !ext_s) state_d = PH_RUN;
      PH_RUN:  if (ext_s) state_d = PH_OST;
      default: state_d = PH_OFF;
    endcase
  end

  // Four-phase handshake: a new request only once the old done has returned low.
  assign req_d = (state_d == PH_OST) && !ext_s && (req_q || !done_s);

  always_ff @(posedge tmr_clk_i) begin
    if (!pg_s) begin
      state_q    <= PH_OFF;
      req_q      <= 1'b0;
      src_q      <= 1'b0;
      core_rst_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      req_q      <= req_d;
      core_rst_q <= (state_d != PH_RUN);
      if (state_q == PH_POR)                src_q <= 1'b0;
      else if (state_q == PH_RUN && ext_s)  src_q <= 1'b1;
    end
  end

  assign core_rst_o = core_rst_q;
  assign phase_o    = state_q;
  assign rst_src_o  = src_q;

  // R2: reset released only in the run phase
  a_r2_release_only_run: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    !core_rst_o |-> phase_o == PH_RUN);

  // R2: reset low throughout the run phase
  a_r2_run_unreset: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    phase_o == PH_RUN |-> !core_rst_o);

  // R3: the power-on pulse lasts one cycle
  a_r3_pulse_single: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    phase_o == PH_POR |=> phase_o == PH_PWRT);

  // R4: power-up wait ends only at the counter's last value
  a_r4_pwrt_full: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    (phase_o == PH_OST && $past(phase_o) == PH_PWRT) |-> $past(pwrt_last));

  // R5: run entered only after the oscillator count reported done
  a_r5_ost_done: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    (phase_o == PH_RUN && $past(phase_o) == PH_OST) |-> $past(done_s));

  // R7: power-up wait never reached from the external path
  a_r7_no_pwrt_reentry: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    phase_o == PH_PWRT |-> ($past(phase_o) == PH_POR || $past(phase_o) == PH_PWRT));

  // R7: source bit set only on entry to the oscillator wait
  a_r7_src_on_ost: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    $rose(rst_src_o) |-> phase_o == PH_OST);

  // R8: held external reset keeps the oscillator request low
  a_r8_ext_holds: assert property (@(posedge tmr_clk_i) disable iff (!pg_s)
    ext_s |=> !req_q);

endmodule

// File: tb/por_sequencer_tb.sv
`timescale 1ns/1ps
module por_sequencer_tb_top;

  localparam int PWRT_CYC = 16;
  localparam int OST_CYC  = 1024;
  localparam int MARGIN   = 14;

  logic       tmr_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic       ext_rst = 1'b0;
  logic       core_rst;
  logic [2:0] phase;
  logic       rst_src;

  int checks = 0;
  int errors = 0;
  int osc_tick = 0;

  always #4 tmr_clk = ~tmr_clk;
  always #5 osc_clk = ~osc_clk;
  always @(posedge osc_clk) osc_tick <= osc_tick + 1;

  por_sequencer #(.PWRT_CYC(PWRT_CYC), .OST_CYC(OST_CYC)) dut_i (
    .tmr_clk_i   (tmr_clk),
    .osc_clk_i   (osc_clk),
    .supply_ok_i (supply_ok),
    .ext_rst_i   (ext_rst),
    .core_rst_o  (core_rst),
    .phase_o     (phase),
    .rst_src_o   (rst_src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge tmr_clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Raise supply, return pulse and power-up lengths; stops on first non-2 phase.
  task automatic rise(output int por_n, output int pwrt_n, output bit rst_hi, input bit poke_ext);
    int g;
    por_n = 0; pwrt_n = 0; rst_hi = 1'b1; g = 0;
    supply_ok = 1'b1;
    while (phase == 3'd0 && g < 10) begin cyc(1); g++; end
    while (phase == 3'd1 && por_n < 10) begin
      if (!core_rst) rst_hi = 1'b0;
      if (poke_ext) ext_rst = 1'b1;
      cyc(1); por_n++;
    end
    while (phase == 3'd2 && pwrt_n < PWRT_CYC + 10) begin
      if (!core_rst) rst_hi = 1'b0;
      if (poke_ext && pwrt_n == 6) ext_rst = 1'b0;
      cyc(1); pwrt_n++;
    end
    ext_rst = 1'b0;
  endtask

  task automatic ost_len(output int osc_n, output bit rst_hi);
    int t0, g;
    rst_hi = 1'b1; g = 0;
    t0 = osc_tick;
    while (phase == 3'd3 && g < 3 * OST_CYC) begin
      if (!core_rst) rst_hi = 1'b0;
      cyc(1); g++;
    end
    osc_n = osc_tick - t0;
  endtask

  task automatic power_off();
    supply_ok = 1'b0;
    cyc(3);
    chk(phase == 3'd0 && core_rst, "R1 off within 3", int'(phase), 0);
    cyc(4);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int pn, wn, on, first_run;
    bit hi, stay, saw2;
    cyc(10);
    chk(phase == 3'd0, "R1 reset phase", int'(phase), 0);
    chk(core_rst == 1'b1, "R2 reset held off", int'(core_rst), 1);
    cyc(20);
    chk(phase == 3'd0, "R1 still off", int'(phase), 0);

    // Full power-on sequence
    rise(pn, wn, hi, 1'b0);
    chk(pn == 1, "R3 pulse length", pn, 1);
    chk(wn == PWRT_CYC, "R4 power-up length", wn, PWRT_CYC);
    chk(phase == 3'd3, "R4 enters oscillator wait", int'(phase), 3);
    ost_len(on, hi);
    chk(hi, "R2 reset high before run", int'(hi), 1);
    chk(on >= OST_CYC && on <= OST_CYC + MARGIN, "R5 oscillator wait", on, OST_CYC);
    chk(phase == 3'd4 && !core_rst, "R2 run releases reset", int'(core_rst), 0);
    chk(rst_src == 1'b0, "R10 power-on source", int'(rst_src), 0);

    // Stays in run
    stay = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (phase != 3'd4 || core_rst) stay = 1'b0;
    end
    chk(stay, "R6 run stable", int'(phase), 4);

    // External reset from run
    ext_rst = 1'b1;
    saw2 = 1'b0;
    cyc(4);
    chk(phase == 3'd3, "R7 external enters oscillator wait", int'(phase), 3);
    chk(rst_src == 1'b1, "R7 source external", int'(rst_src), 1);
    chk(core_rst == 1'b1, "R2 reset during external", int'(core_rst), 1);
    stay = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (phase != 3'd3) stay = 1'b0;
      if (phase == 3'd2) saw2 = 1'b1;
    end
    chk(stay, "R8 held external keeps wait", int'(phase), 3);
    ext_rst = 1'b0;
    ost_len(on, hi);
    chk(on >= OST_CYC && on <= OST_CYC + MARGIN, "R8 full count after release", on, OST_CYC);
    chk(!saw2 && phase == 3'd4, "R7 no power-up wait", int'(saw2), 0);

    // Supply loss from run, then external pokes during pulse and power-up
    power_off();
    rise(pn, wn, hi, 1'b1);
    chk(wn == PWRT_CYC, "R9 power-up unaffected by external", wn, PWRT_CYC);
    ost_len(on, hi);
    chk(phase == 3'd4 && rst_src == 1'b0, "R9 source stays power-on", int'(rst_src), 0);

    // Sweep: drop supply at each offset, then power-up must restart in full
    for (int k = 0; k < PWRT_CYC + 8; k++) begin
      power_off();
      supply_ok = 1'b1;
      cyc(k);
      power_off();
      rise(pn, wn, hi, 1'b0);
      chk(pn == 1 && wn == PWRT_CYC && hi, "R1 restart after drop", wn, PWRT_CYC);
    end

    // Drop mid oscillator wait, then the oscillator count restarts from zero
    cyc(OST_CYC / 4);
    power_off();
    rise(pn, wn, hi, 1'b0);
    ost_len(on, hi);
    first_run = int'(phase);
    chk(on >= OST_CYC && on <= OST_CYC + MARGIN, "R1 oscillator count cleared", on, OST_CYC);
    chk(first_run == 4, "R5 run after restart", first_run, 4);

    summary();
    $finish;
  end

endmodule